// File: doc/BRIEF.md
# Watchdog Timer with Keyed Feed

A bus-mapped watchdog that counts a programmed reload value down and pulses a reset output when the count runs out. A fixed divide-by-4 prescaler paces the 24-bit down-counter. Software sets an enable bit, but counting only begins once a two-write key sequence (0xAA, then 0x55, written to the feed register) has been completed. The same sequence is then the periodic "feed" that reloads the counter before it expires.

The block guards itself against runaway software. The control bits can only be set, never cleared, so nothing short of the external reset disarms it. While it is armed with reset generation on, a key sequence that opens with 0xAA and is then interrupted raises the reset pulse at once. The remaining count can be read at any time.

Registers are selected by word index `bus_addr[3:2]`, and address bits above bit 3 must be zero for a hit. `bus_rdata` is a combinational decode of `bus_addr`. `bus_rd` marks a read access, which matters only to the key sequence.

Top module: `wdog_feedlock`

## Requirements
- R1: While armed, the count drops by one every 4 clocks. A completed key sequence restarts the prescaler, so the first decrement lands on the 4th rising edge after the edge that took the 0x55 write.
- R2: The count is 24 bits wide and reads at offset 0x0C (index 3). After a key sequence with reload N, it reads N-k after 4k clocks. When a tick finds the count at zero (the 4(N+1)th edge), an expiry occurs and the count reloads N.
- R3: A key sequence is a feed-register write (offset 0x08, index 2) with low byte 0xAA, followed by the next bus access being a feed write with low byte 0x55. It reloads the count from the reload register, whether or not the block is enabled.
- R4: Mode bit 0 (enable) alone does not start counting. The block becomes armed only when a key sequence completes while enable is already set.
- R5: The mode register (offset 0x00, index 0) holds enable in bit 0 and reset-enable in bit 1, and reads them back in bits [1:0]. Both bits are set-only, so writing 0 leaves them unchanged.
- R6: With reset-enable clear, an expiry produces no reset pulse; the count reloads and keeps running.
- R7: While armed with reset-enable set, any access after 0xAA other than a 0x55 feed write aborts the sequence and pulses the reset output in the next cycle. This covers another feed value, a write to another register, and any read.
- R8: An aborted sequence while not armed, or while reset-enable is clear, gives no pulse and no reload.
- R9: The reload register (offset 0x04, index 1) takes `bus_wdata[23:0]` and clamps values below 0xFF to 0xFF. It reads back the stored value, and a new value takes effect only at the next reload.
- R10: After reset, mode reads 0, reload reads 0xFF, the count reads 0xFF, the reset output is low, and a read of the feed register returns 0.
- R11: The reset output is high for exactly one clock per event. Only the asynchronous reset input returns the block to its disabled state.
- R12: A feed write with a low byte other than 0xAA, made outside a sequence, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from bus_addr |
| wdt_reset | output | 1 | One-clock reset pulse |

## Verification
A prescaler or counter fault shows up on the count readback within four clocks of a key sequence, and it moves the reset pulse off its predicted edge at 4(N+1) clocks. For that reason the count and the pulse are compared on every cycle of whole periods, for several reload values. A sequence-checker fault shows within one clock: a missing pulse after an aborted key, a spurious pulse after a correct one, or a count that fails to reload. Sticky or clamping faults in the mode and reload registers appear on the next readback.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        REG_MODE   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_FEED   = 2'd2,
        REG_VALUE  = 2'd3
    } wdog_reg_e;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HALF = 1'b1
    } wdog_seq_e;

    localparam logic [7:0] KEY_OPEN  = 8'hAA;
    localparam logic [7:0] KEY_CLOSE = 8'h55;

endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    assign tick = (pre_q == LAST);

    always_comb begin
        pre_d = pre_q + PW'(1);
        if (clr || tick) pre_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R1: ticks are never adjacent
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R1: a clear restarts the phase, so no tick on the next cycle
    a_r1_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);

endmodule

// File: rtl/wdog_feed_seq.sv
module wdog_feed_seq
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       feed_wr,
    input  logic [7:0] key,
    output logic       feed_ok,
    output logic       feed_bad
);
    wdog_seq_e seq_d, seq_q;

    always_comb begin
        seq_d    = seq_q;
        feed_ok  = 1'b0;
        feed_bad = 1'b0;
        case (seq_q)
            SEQ_IDLE: begin
                if (feed_wr && key == KEY_OPEN) seq_d = SEQ_HALF;
            end
            SEQ_HALF: begin
                if (acc) begin
                    seq_d = SEQ_IDLE;
                    if (feed_wr && key == KEY_CLOSE) feed_ok  = 1'b1;
                    else                             feed_bad = 1'b1;
                end
            end
            default: seq_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_IDLE;
        else        seq_q <= seq_d;
    end

    // R7: a sequence closes once; the next cycle cannot close another
    a_r7_seq_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_ok || feed_bad) |=> !(feed_ok || feed_bad));

    // R3: a close needs an access in that cycle
    a_r3_close_on_access: assert property (@(posedge clk) disable iff (!rst_n)
        (feed_ok || feed_bad) |-> acc);

endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
    parameter int CNT_W   = 24,
    parameter int RST_VAL = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign expire = run && tick && !load && (cnt_q == '0);
    assign count  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load || expire)   cnt_d = load_val;
        else if (run && tick) cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_W'(RST_VAL);
        else        cnt_q <= cnt_d;
    end

    // R2: one step down per tick while running
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    // R4: no movement while idle and not loading
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(cnt_q));

endmodule

// File: rtl/wdog_feedlock.sv
module wdog_feedlock #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int CNT_W      = 24,
    parameter int DIV        = 4,
    parameter int RELOAD_MIN = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdt_reset
);
    import wdog_pkg::*;

    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(RELOAD_MIN);

    typedef struct packed {
        logic             en;
        logic             rst_en;
        logic             armed;
        logic [CNT_W-1:0] reload;
        logic             pulse;
    } ctl_t;

    ctl_t d, q;

    logic             in_range;
    wdog_reg_e        idx;
    logic             acc;
    logic             wr_mode, wr_reload, wr_feed;
    logic             feed_ok, feed_bad;
    logic             tick, expire;
    logic [CNT_W-1:0] tv;
    logic [CNT_W-1:0] wr_val;
    logic             unused_bits;

    assign in_range  = ((bus_addr >> 4) == '0);
    assign idx       = wdog_reg_e'(bus_addr[3:2]);
    assign acc       = bus_wr || bus_rd;
    assign wr_mode   = bus_wr && in_range && (idx == REG_MODE);
    assign wr_reload = bus_wr && in_range && (idx == REG_RELOAD);
    assign wr_feed   = bus_wr && in_range && (idx == REG_FEED);
    assign wr_val    = bus_wdata[CNT_W-1:0];
    assign unused_bits = ^{bus_wdata[DATA_W-1:CNT_W], bus_addr[1:0]};

    wdog_feed_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .feed_wr  (wr_feed),
        .key      (bus_wdata[7:0]),
        .feed_ok  (feed_ok),
        .feed_bad (feed_bad)
    );

    wdog_prescale #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (feed_ok),
        .tick  (tick)
    );

    wdog_countdown #(.CNT_W(CNT_W), .RST_VAL(RELOAD_MIN)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (q.armed),
        .tick     (tick),
        .load     (feed_ok),
        .load_val (q.reload),
        .count    (tv),
        .expire   (expire)
    );

    always_comb begin
        d       = q;
        d.pulse = 1'b0;
        if (wr_mode) begin
            d.en     = q.en     | bus_wdata[0];
            d.rst_en = q.rst_en | bus_wdata[1];
        end
        if (wr_reload) d.reload = (wr_val < MIN_V) ? MIN_V : wr_val;
        if (feed_ok && q.en) d.armed = 1'b1;
        d.pulse = q.rst_en && ((q.armed && feed_bad) || expire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{en: 1'b0, rst_en: 1'b0, armed: 1'b0, reload: MIN_V, pulse: 1'b0};
        else        q <= d;
    end

    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            case (idx)
                REG_MODE:   bus_rdata = DATA_W'({q.rst_en, q.en});
                REG_RELOAD: bus_rdata = DATA_W'(q.reload);
                REG_VALUE:  bus_rdata = DATA_W'(tv);
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign wdt_reset = q.pulse;

    // R5: control bits never clear
    a_r5_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.en |=> q.en);
    a_r5_rsten_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.rst_en |=> q.rst_en);

    // R4: arming follows a completed sequence with enable set
    a_r4_arm_needs_feed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.armed) |-> $past(feed_ok && q.en));

    // R3: a completed sequence loads the count from the reload register
    a_r3_feed_loads: assert property (@(posedge clk) disable iff (!rst_n)
        feed_ok |=> (tv == $past(q.reload)));

    // R6: no pulse without reset-enable
    a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !q.rst_en |=> !wdt_reset);

    // R11: pulse lasts one clock
    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_reset |=> !wdt_reset);

    // R9: stored reload never below the floor
    a_r9_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
        q.reload >= MIN_V);

endmodule

// File: tb/test_wdog_feedlock.sv
`timescale 1ns/1ps
module test_wdog_feedlock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = 4'hC;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_reset;

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    wdog_feedlock i_wdog_feedlock (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_reset(wdt_reset)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 4'hC;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 4'hC;
    endtask

    task automatic peek(input logic [3:0] a, output logic [31:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
        bus_addr = 4'hC;
    endtask

    task automatic feed();
        wr(4'h8, 32'hAA);
        wr(4'h8, 32'h55);
    endtask

    // Follows one whole period after a feed: count and pulse every cycle
    task automatic sweep(input int n, input bit pulse_on);
        int last;
        last = 4 * (n + 1);
        for (int k = 1; k <= last + 1; k++) begin
            int exp_tv;
            @(negedge clk);
            exp_tv = (k < last) ? (n - k / 4) : n;
            chk("R1 R2 count", bus_rdata, 32'(exp_tv));
            chk(pulse_on ? "R2 R11 pulse" : "R6 no pulse", 32'(wdt_reset),
                32'((pulse_on && k == last) ? 1 : 0));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R10 reset state
        peek(4'h0, v); chk("R10 mode", v, 32'h0);
        peek(4'h4, v); chk("R10 reload", v, 32'hFF);
        peek(4'hC, v); chk("R10 count", v, 32'hFF);
        chk("R10 pulse", 32'(wdt_reset), 32'h0);
        rst_n = 1'b1;
        peek(4'h8, v); chk("R10 feed read", v, 32'h0);

        // R12 stray feed value
        wr(4'h8, 32'h12);
        peek(4'hC, v); chk("R12 count", v, 32'hFF);
        chk("R12 pulse", 32'(wdt_reset), 32'h0);

        // R9 reload register
        wr(4'h4, 32'h10);       peek(4'h4, v); chk("R9 clamp", v, 32'hFF);
        wr(4'h4, 32'hFFFFFF);   peek(4'h4, v); chk("R9 max", v, 32'hFFFFFF);
        wr(4'h4, 32'hAB000105); peek(4'h4, v); chk("R9 upper ignored", v, 32'h105);
        wr(4'h4, 32'h100);

        // R8 abort while unarmed, R4 enable alone
        wr(4'h8, 32'hAA);
        wr(4'h0, 32'h1);
        chk("R8 no pulse unarmed", 32'(wdt_reset), 32'h0);
        repeat (20) @(negedge clk);
        peek(4'hC, v); chk("R4 count idle", v, 32'hFF);
        peek(4'h0, v); chk("R5 enable set", v, 32'h1);

        // R4 arm, R6 expiry without reset-enable
        feed();
        peek(4'hC, v); chk("R3 reload", v, 32'h100);
        sweep(32'h100, 1'b0);

        // R8 armed but reset-enable clear
        wr(4'h8, 32'hAA);
        rd(4'h0, v);
        chk("R8 no pulse rst_en=0", 32'(wdt_reset), 32'h0);

        // R5 set-only bits
        wr(4'h0, 32'h0); peek(4'h0, v); chk("R5 clear ignored", v, 32'h1);
        wr(4'h0, 32'h2); peek(4'h0, v); chk("R5 rst_en set", v, 32'h3);
        wr(4'h0, 32'h0); peek(4'h0, v); chk("R5 still set", v, 32'h3);

        // R2 R1 R11 expiry with pulse
        wr(4'h4, 32'h7); peek(4'h4, v); chk("R9 clamp low", v, 32'hFF);
        feed();
        sweep(32'hFF, 1'b1);
        wr(4'h4, 32'h102);
        feed();
        sweep(32'h102, 1'b1);

        // R9 reload change deferred
        wr(4'h4, 32'h200);
        peek(4'hC, v); chk("R9 deferred", v, 32'h102);
        feed();
        peek(4'hC, v); chk("R3 new reload", v, 32'h200);

        // R7 bad sequences
        wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
        chk("R7 AA AA", 32'(wdt_reset), 32'h1);
        @(negedge clk); chk("R11 pulse ends", 32'(wdt_reset), 32'h0);
        wr(4'h8, 32'hAA); wr(4'h0, 32'h0);
        chk("R7 other write", 32'(wdt_reset), 32'h1);
        wr(4'h8, 32'hAA); rd(4'h4, v);
        chk("R7 read abort", 32'(wdt_reset), 32'h1);
        feed();
        chk("R3 good feed quiet", 32'(wdt_reset), 32'h0);
        wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
        chk("R7 AA 55 AA AA", 32'(wdt_reset), 32'h1);

        // R11 only async reset disarms
        @(negedge clk);
        rst_n = 1'b0;
        peek(4'h0, v); chk("R11 mode cleared", v, 32'h0);
        peek(4'h4, v); chk("R11 reload default", v, 32'hFF);
        peek(4'hC, v); chk("R11 count default", v, 32'hFF);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        peek(4'hC, v); chk("R11 idle after reset", v, 32'hFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule